// File: doc/BRIEF.md
# Class-Keyed Instruction Fetch Cache

This block is the instruction cache and fetch sequencer of a 32-bit core. It is built to make dynamic method dispatch fast. In normal operation each fetch looks up a line by a hash of the program counter. The block returns the addressed word, and the PC moves on by one word each time the core takes a response.

A dispatch command switches the block into dispatch operation. The lookup key then becomes a 64-bit pair: a site value in the upper half and the receiver's class pointer in the lower half. The site value is either the current PC or an explicit value given with the command, which lets several call sites share entries. The matching line holds one complete dispatch entry. Its words are issued in order from word 0 while the PC stays frozen. A branch or call, delivered as a redirect, leaves dispatch operation, and fetch continues in normal operation at the target.

The cache is direct-mapped. A miss requests a whole line from memory, holds off responses until the line arrives, and then installs it. Each line stores a mode bit and the full unhashed key, so a normal line and a dispatch line never match each other. Lookup takes the same time however many entries a site has.

Top module: `dispatch_fetch_cache`

## Requirements
- R1: While reset is held and in the first cycle after it, rsp_valid, disp_mode, disp_overrun and rf_req are 0 and rsp_pc equals RESET_PC (0).
- R2: In normal mode a valid response carries word pc[4:2] of the line whose key is {32'h0, pc[31:5], 5'b0}, stored with mode bit 0.
- R3: In normal mode, rsp_pc grows by 4 after each cycle with rsp_valid && rsp_ready, unless a redirect or dispatch command is present; otherwise it holds.
- R4: A dispatch command sets disp_mode and selects key {site, class}, where site is disp_site when disp_use_site is 1 and the current rsp_pc otherwise. Responses then issue words 0, 1, 2 … of that line, stored with mode bit 1.
- R5: In dispatch mode rsp_pc never changes except by redirect, and the word index advances by one per accepted response.
- R6: A redirect clears disp_mode and loads rsp_pc with redir_pc in the next cycle. This holds even when the last dispatch word is accepted in the same cycle, and no overrun is flagged then.
- R7: Accepting word 7 in dispatch mode without a redirect or command raises disp_overrun for exactly one cycle and returns to normal mode with rsp_pc unchanged.
- R8: On a miss rf_req rises with rf_mode/rf_key naming the missed line. It stays high with a stable key until rf_valid, and rsp_valid is 0 while it is high. rf_data word i sits at bits [32*i+31:32*i].
- R9: A dispatch key numerically equal to a normal line's key is a distinct line: it misses and is refilled with mode bit 1.
- R10: Walking through the 8 words of one freshly missed normal line causes exactly one refill.
- R11: Redirect outranks a dispatch command, and a dispatch command outranks the advance of an accepted response, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_ready | input | 1 | Core accepts the current response |
| rsp_valid | output | 1 | Response word is valid |
| rsp_instr | output | 32 | Fetched instruction word |
| rsp_pc | output | 32 | Architectural PC |
| disp_go | input | 1 | Enter dispatch mode |
| disp_use_site | input | 1 | Use disp_site rather than the PC as key upper half |
| disp_site | input | 32 | Explicit site value |
| disp_class | input | 32 | Receiver class pointer |
| redir_valid | input | 1 | Branch or call taken |
| redir_pc | input | 32 | Redirect target |
| disp_mode | output | 1 | Dispatch mode active |
| disp_overrun | output | 1 | One-cycle flag: dispatch ran past the line end |
| rf_req | output | 1 | Line refill request (level) |
| rf_mode | output | 1 | Mode bit of the requested line |
| rf_key | output | 64 | Unhashed key of the requested line |
| rf_valid | input | 1 | Refill data present |
| rf_data | input | 256 | Refill line, word 0 in the low bits |

## Verification
The sharpest collision is a redirect arriving in the same cycle that the core accepts the final word of a dispatch line. That cycle is also the one that would otherwise raise the overrun flag. A directed case stalls the core on word 7 until the line is resident, then asserts the redirect and rsp_ready together. The bench expects the new PC, normal mode and no overrun pulse. Random traffic also mixes redirects and dispatch commands with accepted responses and pending refills, and a bench model of PC, mode and word index judges every cycle.

// File: rtl/dispatch_fetch_cache.sv
module dispatch_fetch_cache #(
  parameter int LINES    = 64,
  parameter int WORDS    = 8,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rsp_ready,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_instr,
  output logic [31:0]           rsp_pc,
  input  logic                  disp_go,
  input  logic                  disp_use_site,
  input  logic [31:0]           disp_site,
  input  logic [31:0]           disp_class,
  input  logic                  redir_valid,
  input  logic [31:0]           redir_pc,
  output logic                  disp_mode,
  output logic                  disp_overrun,
  output logic                  rf_req,
  output logic                  rf_mode,
  output logic [63:0]           rf_key,
  input  logic                  rf_valid,
  input  logic [WORDS*32-1:0]   rf_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int LB    = OFF_W + 2;

  function automatic logic [IDX_W-1:0] fold(input logic [63:0] k);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < 64; i += IDX_W) h = h ^ IDX_W'(k >> i);
    return h;
  endfunction

  logic [31:0]      pc_q, site_q, cls_q;
  logic             disp_q, err_q;
  logic [OFF_W-1:0] off_q;
  logic             pend_q, pend_mode_q;
  logic [63:0]      pend_key_q;
  logic [IDX_W-1:0] pend_idx_q;

  logic                    vld_q  [LINES];
  logic                    mtag_q [LINES];
  logic [63:0]             ktag_q [LINES];
  logic [WORDS-1:0][31:0]  data_q [LINES];

  wire [63:0]      key  = disp_q ? {site_q, cls_q} : {32'h0, pc_q[31:LB], {LB{1'b0}}};
  wire [IDX_W-1:0] idx  = fold(disp_q ? key : key >> LB);
  wire [OFF_W-1:0] wsel = disp_q ? off_q : pc_q[LB-1:2];
  wire             hit  = vld_q[idx] && (mtag_q[idx] == disp_q) && (ktag_q[idx] == key);
  wire             acc  = rsp_valid && rsp_ready;
  wire             last = disp_q && (off_q == OFF_W'(WORDS-1));

  assign rsp_valid    = hit && !pend_q;
  assign rsp_instr    = data_q[idx][wsel];
  assign rsp_pc       = pc_q;
  assign disp_mode    = disp_q;
  assign disp_overrun = err_q;
  assign rf_req       = pend_q;
  assign rf_mode      = pend_mode_q;
  assign rf_key       = pend_key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      disp_q <= 1'b0;
      off_q  <= '0;
      site_q <= '0;
      cls_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (redir_valid) begin
        pc_q   <= redir_pc;
        disp_q <= 1'b0;
        off_q  <= '0;
      end else if (disp_go) begin
        disp_q <= 1'b1;
        site_q <= disp_use_site ? disp_site : pc_q;
        cls_q  <= disp_class;
        off_q  <= '0;
      end else if (acc) begin
        if (!disp_q) begin
          pc_q <= pc_q + 32'd4;
        end else if (last) begin
          disp_q <= 1'b0;
          off_q  <= '0;
          err_q  <= 1'b1;
        end else begin
          off_q <= off_q + OFF_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_mode_q <= 1'b0;
      pend_key_q  <= '0;
      pend_idx_q  <= '0;
    end else if (pend_q) begin
      if (rf_valid) pend_q <= 1'b0;
    end else if (!hit) begin
      pend_q      <= 1'b1;
      pend_mode_q <= disp_q;
      pend_key_q  <= key;
      pend_idx_q  <= idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) vld_q[i] <= 1'b0;
    end else if (pend_q && rf_valid) begin
      vld_q[pend_idx_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_q && rf_valid) begin
      mtag_q[pend_idx_q] <= pend_mode_q;
      ktag_q[pend_idx_q] <= pend_key_q;
      data_q[pend_idx_q] <= rf_data;
    end
  end
endmodule

// File: rtl/dispatch_fetch_cache_sva.sv
module dispatch_fetch_cache_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_pc,
  input logic        disp_go,
  input logic        redir_valid,
  input logic [31:0] redir_pc,
  input logic        disp_mode,
  input logic        disp_overrun,
  input logic        rf_req,
  input logic        rf_mode,
  input logic [63:0] rf_key,
  input logic        rf_valid
);
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_mode && rsp_valid && rsp_ready && !redir_valid && !disp_go) |=> rsp_pc == $past(rsp_pc) + 32'd4); // R3
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_mode && !redir_valid) |=> $stable(rsp_pc)); // R5
  AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (!disp_mode && rsp_pc == $past(redir_pc))); // R6
  AST_OVERRUN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    disp_overrun |-> !disp_mode); // R7
  AST_OVERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_overrun |=> !disp_overrun); // R7
  AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && !rf_valid) |=> (rf_req && $stable(rf_key) && $stable(rf_mode))); // R8
  AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |-> !rsp_valid); // R8
endmodule

bind dispatch_fetch_cache dispatch_fetch_cache_sva i_sva (.*);

// File: tb/test_dispatch_fetch_cache.sv
module test_dispatch_fetch_cache;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, rsp_ready, rsp_valid, disp_go, disp_use_site, redir_valid;
  logic disp_mode, disp_overrun, rf_req, rf_mode, rf_valid;
  logic [31:0] rsp_instr, rsp_pc, disp_site, disp_class, redir_pc;
  logic [63:0] rf_key;
  logic [255:0] rf_data;

  dispatch_fetch_cache i_dispatch_fetch_cache (.*);

  int errors = 0, checks = 0, refills = 0, mem_cnt = 0;
  bit done = 0, mem_busy = 0, rf_prev = 0;
  logic [31:0] exp_pc = 0, exp_site = 0, exp_cls = 0;
  logic exp_disp = 0, exp_err = 0, prev_mode = 0;
  logic [2:0] exp_off = 0;
  logic [63:0] prev_key = 0;

  function automatic logic [31:0] mw(input logic m, input logic [63:0] k, input int i);
    return (k[31:0] * 32'h9E3779B1) ^ (k[63:32] * 32'h85EBCA6B) ^ (32'(i) * 32'h01000193) ^ (m ? 32'hA5A50000 : 32'h0);
  endfunction

  function automatic logic [63:0] ekey();
    return exp_disp ? {exp_site, exp_cls} : {32'h0, exp_pc[31:5], 5'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit rd, input logic [31:0] rpc, input bit go, input bit us,
                     input logic [31:0] st, input logic [31:0] cl, input bit rdy);
    bit acc;
    @(negedge clk);
    chk(rsp_pc == exp_pc, "R3 R5 pc", rsp_pc, exp_pc);
    chk(disp_mode == exp_disp, "R6 mode", disp_mode, exp_disp);
    chk(disp_overrun == exp_err, "R7 overrun", disp_overrun, exp_err);
    if (rsp_valid)
      chk(rsp_instr == mw(exp_disp, ekey(), exp_disp ? int'(exp_off) : int'(exp_pc[4:2])),
          exp_disp ? "R4 dispatch word" : "R2 normal word", rsp_instr,
          mw(exp_disp, ekey(), exp_disp ? int'(exp_off) : int'(exp_pc[4:2])));
    if (rf_req && !rf_prev) begin
      refills++;
      chk(rf_key == prev_key && rf_mode == prev_mode, "R8 refill key", {rf_mode, rf_key[62:0]}, {prev_mode, prev_key[62:0]});
    end
    rf_prev = rf_req;
    if (!mem_busy && rf_req) begin mem_busy = 1; mem_cnt = 2; end
    rf_valid = 1'b0;
    if (mem_busy) begin
      if (mem_cnt == 0) begin
        for (int i = 0; i < 8; i++) rf_data[32*i +: 32] = mw(rf_mode, rf_key, i);
        rf_valid = 1'b1;
        mem_busy = 0;
      end else mem_cnt--;
    end
    redir_valid = rd; redir_pc = rpc; disp_go = go; disp_use_site = us;
    disp_site = st; disp_class = cl; rsp_ready = rdy;
    acc = rsp_valid && rdy;
    prev_key = ekey(); prev_mode = exp_disp;
    exp_err = 0;
    if (rd) begin exp_pc = rpc; exp_disp = 0; exp_off = 0; end
    else if (go) begin exp_disp = 1; exp_site = us ? st : exp_pc; exp_cls = cl; exp_off = 0; end
    else if (acc) begin
      if (!exp_disp) exp_pc = exp_pc + 4;
      else if (exp_off == 3'd7) begin exp_disp = 0; exp_off = 0; exp_err = 1; end
      else exp_off = exp_off + 1;
    end
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, rdy);
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int r0;
    logic [31:0] held;
    void'($urandom(32'd20240611));
    rst_n = 0; rsp_ready = 0; disp_go = 0; disp_use_site = 0; disp_site = 0;
    disp_class = 0; redir_valid = 0; redir_pc = 0; rf_valid = 0; rf_data = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rsp_valid && !disp_mode && !disp_overrun && !rf_req && rsp_pc == 32'h0, "R1 reset",
          {rsp_valid, disp_mode, rf_req, rsp_pc}, 64'h0);
    end
    rst_n = 1;

    // R10: one refill for a whole fresh line
    cyc(1, 32'h1000, 0, 0, 0, 0, 0);
    r0 = refills;
    for (int i = 0; i < 200 && exp_pc < 32'h1020; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    chk(refills == r0 + 1, "R10 single refill", refills - r0, 1);
    chk(exp_pc == 32'h1020, "R3 walk", exp_pc, 32'h1020);

    // R4 with PC as site, then R11 command beats accept
    cyc(0, 0, 1, 0, 0, 32'hC0DE0000, 0);
    idle(8, 0);
    held = exp_pc;
    cyc(0, 0, 1, 0, 0, 32'hC0DE0040, 1);
    idle(1, 0);
    chk(rsp_pc == held && disp_mode, "R11 command over accept", rsp_pc, held);
    for (int i = 0; i < 100 && exp_off < 3'd7; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    idle(6, 0);
    chk(rsp_valid, "R6 last word ready", rsp_valid, 1);
    cyc(1, 32'h1040, 0, 0, 0, 0, 1);
    idle(1, 0);
    chk(!disp_overrun && !disp_mode && rsp_pc == 32'h1040, "R6 redirect on last word",
        {disp_overrun, disp_mode, rsp_pc}, {2'b00, 32'h1040});

    // R7 overrun
    cyc(0, 0, 1, 1, 32'h5000, 32'h77, 0);
    held = exp_pc;
    for (int i = 0; i < 100 && !exp_err; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(disp_overrun && !disp_mode && rsp_pc == held, "R7 overrun flag", {disp_overrun, disp_mode, rsp_pc}, {2'b10, held});
    idle(1, 0);
    chk(!disp_overrun, "R7 one cycle", disp_overrun, 0);

    // R9 no aliasing between modes
    cyc(1, 32'h2000, 0, 0, 0, 0, 0);
    idle(8, 0);
    chk(rsp_valid && rsp_instr == mw(0, 64'h2000, 0), "R2 line 0x2000", rsp_instr, mw(0, 64'h2000, 0));
    r0 = refills;
    cyc(0, 0, 1, 1, 32'h0, 32'h2000, 0);
    idle(8, 0);
    chk(refills == r0 + 1, "R9 separate refill", refills - r0, 1);
    chk(rsp_valid && rsp_instr == mw(1, 64'h2000, 0), "R9 dispatch data", rsp_instr, mw(1, 64'h2000, 0));

    // R11 redirect beats command
    cyc(1, 32'h3000, 1, 1, 32'hAA, 32'hBB, 1);
    idle(1, 0);
    chk(!disp_mode && rsp_pc == 32'h3000, "R11 redirect over command", rsp_pc, 32'h3000);

    // R8 stall during refill
    cyc(1, 32'h8000, 0, 0, 0, 0, 1);
    idle(2, 1);
    chk(rf_req && !rsp_valid, "R8 stalled", {rf_req, rsp_valid}, 2'b10);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int p;
      bit rd, go, us, rdy;
      logic [31:0] st, cl;
      p   = int'($urandom_range(99));
      rd  = p < 5;
      go  = (p >= 5) && (p < 11);
      us  = $urandom_range(1) == 1;
      st  = 32'h4000 + 32'($urandom_range(3)) * 32'h40;
      cl  = 32'h100 * (32'($urandom_range(2)) + 1);
      rdy = $urandom_range(99) < 80;
      cyc(rd, {23'h0, 7'($urandom_range(127)), 2'b00}, go, us, st, cl, rdy);
    end
    summary();
  end
endmodule